// File: doc/BRIEF.md
# Burst Column Address Generator

This block sits in the command path of a synchronous DRAM controller or device model. When a READ or WRITE column command is accepted, it takes the starting column and the current mode settings and produces the column address for each beat of the burst, one per clock. It supports burst lengths of 1, 2, 4 and 8 and a full-page length. Beats follow either a sequential (wrapping increment) order or an interleaved (XOR) order, and they always stay inside the aligned block that the starting column selects.

The mode settings are sampled together with the start pulse. These settings are the 3-bit length code, the interleave select and the single-location-write select. A new start may arrive on any clock and it replaces whatever burst is running. A full-page burst keeps going around the page until the stop input ends it. The outputs are a valid flag, a flag marking the final beat of a fixed-length burst, and an error flag that marks bursts started with an unsupported setting.

Top module: `burst_col_gen`

## Requirements
- R1: A start pulse registered at clock edge n makes `valid_o` high from edge n onward, with `col_o` equal to the start column in that first beat. Each following beat appears one clock after the previous one.
- R2: Length codes map as 000 to 1 beat, 001 to 2, 010 to 4, 011 to 8 and 111 to full page. For lengths 2, 4 and 8, the column bits above bit 0, bit 1 or bit 2 respectively keep the start column's value for every beat.
- R3: With interleave low, beat k carries the low log2(L) bits equal to (start + k) mod L.
- R4: With interleave high, beat k carries the low log2(L) bits equal to start XOR k.
- R5: A full-page burst (code 111, interleave low) gives column (start + k) mod 2^COL_W. It wraps past the top column and never ends by itself. `last_o` stays low throughout.
- R6: With length code 000, exactly one beat with the start column is produced, whatever the interleave input is.
- R7: When the single-location-write input is high, a write start produces one beat. A read start under the same settings uses the programmed length, and so does a write start with the input low.
- R8: Length codes 100, 101 and 110, and code 111 together with interleave high, produce a single beat carrying the start column. `err_o` is high for that beat only.
- R9: `last_o` is high exactly on the final beat of a fixed-length burst. On the next clock `valid_o` is low unless a new start was registered.
- R10: A start registered while a burst is running replaces it on the next beat. A start registered together with stop wins over the stop.
- R11: A stop registered without a start ends the burst: `valid_o` is low from the next beat onward.
- R12: After reset `valid_o`, `last_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Column command accepted this cycle |
| is_write_i | input | 1 | Command is a write (1) or a read (0) |
| col_i | input | COL_W | Starting column |
| len_code_i | input | 3 | Burst length code |
| interleave_i | input | 1 | 1 selects interleaved order, 0 sequential |
| wr_single_i | input | 1 | 1 makes write bursts a single location |
| stop_i | input | 1 | Terminate the running burst |
| col_o | output | COL_W | Column of the current beat |
| valid_o | output | 1 | A beat is present |
| last_o | output | 1 | Final beat of a fixed-length burst |
| err_o | output | 1 | Burst started with an unsupported setting |

## Verification
The bound checker watches the cycle-level rules on every cycle:
- the first beat after a start carries the start column;
- a final beat, a lone stop or an error beat is followed by no beat unless a new start arrives;
- `last_o` and `err_o` never appear without `valid_o`;
- a running burst with no last beat, stop or start continues.

Only the directed scenarios can show the address orderings themselves. These are the sequential and XOR sequences, block alignment of the upper bits, the full-page wrap past the top column, the read/write split of the single-location mode, and the handling of reserved codes.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

   localparam logic [2:0] LEN_ONE  = 3'b000;
   localparam logic [2:0] LEN_TWO  = 3'b001;
   localparam logic [2:0] LEN_FOUR = 3'b010;
   localparam logic [2:0] LEN_8    = 3'b011;
   localparam logic [2:0] LEN_PAGE = 3'b111;

   // decoded shape of one burst
   typedef struct packed {
      logic [1:0] lg;    // log2 of fixed length
      logic       full;  // full-page burst
      logic       err;   // unsupported setting seen
   } burst_shape_t;

endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode
   import bcg_pkg::*;
(
   input  logic [2:0]   len_code_i,
   input  logic         interleave_i,
   input  logic         is_write_i,
   input  logic         wr_single_i,
   output burst_shape_t shape_o
);

   logic reserved_code;
   logic page_il;
   logic force_one;

   always_comb begin
      reserved_code = (len_code_i[2] == 1'b1) && (len_code_i != LEN_PAGE);
      page_il       = (len_code_i == LEN_PAGE) && interleave_i;
      force_one     = reserved_code || page_il || (is_write_i && wr_single_i);

      shape_o.err  = reserved_code || page_il;
      shape_o.full = !force_one && (len_code_i == LEN_PAGE);
      if (force_one) begin
         shape_o.lg = 2'd0;
      end else begin
         unique case (len_code_i)
            LEN_TWO:  shape_o.lg = 2'd1;
            LEN_FOUR: shape_o.lg = 2'd2;
            LEN_8:    shape_o.lg = 2'd3;
            default:  shape_o.lg = 2'd0;
         endcase
      end
   end

endmodule

// File: rtl/bcg_beat_ctr.sv
module bcg_beat_ctr #(
   parameter int COL_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             stop_i,
   input  logic             full_i,
   input  logic [COL_W-1:0] mask_i,
   output logic [COL_W-1:0] cnt_o,
   output logic             active_o,
   output logic             final_o
);

   logic [COL_W-1:0] cnt_q;
   logic             active_q;

   assign final_o  = active_q && !full_i && (cnt_q == mask_i);
   assign cnt_o    = cnt_q;
   assign active_o = active_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         active_q <= 1'b0;
      end else if (start_i) begin
         cnt_q    <= '0;
         active_q <= 1'b1;
      end else if (stop_i || final_o) begin
         cnt_q    <= '0;
         active_q <= 1'b0;
      end else if (active_q) begin
         cnt_q    <= cnt_q + 1'b1;   // full page wraps modulo 2^COL_W
      end
   end

endmodule

// File: rtl/bcg_addr_map.sv
module bcg_addr_map #(
   parameter int COL_W = 9
) (
   input  logic [COL_W-1:0] base_i,
   input  logic [COL_W-1:0] cnt_i,
   input  logic [COL_W-1:0] mask_i,
   input  logic             interleave_i,
   output logic [COL_W-1:0] col_o
);

   logic [COL_W-1:0] seq_col;
   logic [COL_W-1:0] xor_col;

   assign seq_col = base_i + cnt_i;
   assign xor_col = base_i ^ cnt_i;

   // per bit: bits inside the block follow the order, bits above hold
   for (genvar b = 0; b < COL_W; b++) begin : g_bit
      assign col_o[b] = !mask_i[b]   ? base_i[b]  :
                        interleave_i ? xor_col[b] : seq_col[b];
   end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
   import bcg_pkg::*;
#(
   parameter int COL_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             is_write_i,
   input  logic [COL_W-1:0] col_i,
   input  logic [2:0]       len_code_i,
   input  logic             interleave_i,
   input  logic             wr_single_i,
   input  logic             stop_i,
   output logic [COL_W-1:0] col_o,
   output logic             valid_o,
   output logic             last_o,
   output logic             err_o
);

   localparam int FIXED_MAX = 8;

   if (COL_W < $clog2(FIXED_MAX)) begin : g_bad_width
      $error("burst_col_gen: COL_W must cover the longest fixed burst");
   end

   burst_shape_t     shape;
   logic [COL_W-1:0] mask_d;
   logic [COL_W-1:0] base_q;
   logic [COL_W-1:0] mask_q;
   logic             full_q;
   logic             il_q;
   logic             err_q;
   logic [COL_W-1:0] cnt;
   logic             active;
   logic             final_beat;

   bcg_len_decode u_dec (
      .len_code_i   (len_code_i),
      .interleave_i (interleave_i),
      .is_write_i   (is_write_i),
      .wr_single_i  (wr_single_i),
      .shape_o      (shape)
   );

   always_comb begin
      if (shape.full) mask_d = '1;
      else            mask_d = COL_W'((1 << shape.lg) - 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         mask_q <= '0;
         full_q <= 1'b0;
         il_q   <= 1'b0;
         err_q  <= 1'b0;
      end else if (start_i) begin
         base_q <= col_i;
         mask_q <= mask_d;
         full_q <= shape.full;
         il_q   <= interleave_i && !shape.full;
         err_q  <= shape.err;
      end
   end

   bcg_beat_ctr #(.COL_W(COL_W)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .stop_i   (stop_i),
      .full_i   (full_q),
      .mask_i   (mask_q),
      .cnt_o    (cnt),
      .active_o (active),
      .final_o  (final_beat)
   );

   bcg_addr_map #(.COL_W(COL_W)) u_map (
      .base_i       (base_q),
      .cnt_i        (cnt),
      .mask_i       (mask_q),
      .interleave_i (il_q),
      .col_o        (col_o)
   );

   assign valid_o = active;
   assign last_o  = final_beat;
   assign err_o   = active && err_q;

endmodule

// File: rtl/bcg_checker.sv
module bcg_checker #(
   parameter int COL_W = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             stop_i,
   input logic [COL_W-1:0] col_i,
   input logic [COL_W-1:0] col_o,
   input logic             valid_o,
   input logic             last_o,
   input logic             err_o
);

   assert_first_beat_R1: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (valid_o && col_o == $past(col_i)));

   assert_last_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (last_o && !start_i) |=> !valid_o);

   assert_last_has_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |-> valid_o);

   assert_stop_ends_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_i && !start_i) |=> !valid_o);

   assert_err_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (valid_o && last_o));

   assert_runs_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !last_o && !stop_i) |=> valid_o);

   assert_start_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && stop_i) |=> valid_o);

endmodule

bind burst_col_gen bcg_checker #(.COL_W(COL_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start_i (start_i),
   .stop_i  (stop_i),
   .col_i   (col_i),
   .col_o   (col_o),
   .valid_o (valid_o),
   .last_o  (last_o),
   .err_o   (err_o)
);

// File: tb/burst_col_gen_tb.sv
module burst_col_gen_tb;

   localparam int CW = 9;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic          is_write_i = 1'b0;
   logic [CW-1:0] col_i = '0;
   logic [2:0]    len_code_i = 3'b000;
   logic          interleave_i = 1'b0;
   logic          wr_single_i = 1'b0;
   logic          stop_i = 1'b0;
   logic [CW-1:0] col_o;
   logic          valid_o, last_o, err_o;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #10 clk = ~clk;   // 50 MHz

   burst_col_gen #(.COL_W(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .is_write_i(is_write_i),
      .col_i(col_i), .len_code_i(len_code_i), .interleave_i(interleave_i),
      .wr_single_i(wr_single_i), .stop_i(stop_i), .col_o(col_o),
      .valid_o(valid_o), .last_o(last_o), .err_o(err_o)
   );

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int exp_col(input int st, input int len, input bit il, input int k);
      int m = len - 1;
      if (il) return (st & ~m) | ((st ^ k) & m);
      return (st & ~m) | ((st + k) & m);
   endfunction

   // drive a start; returns at the negedge where beat 0 is visible
   task automatic kick(input int c, input int code, input bit il, input bit wr, input bit ws);
      @(negedge clk);
      start_i = 1'b1; col_i = CW'(c); len_code_i = 3'(code);
      interleave_i = il; is_write_i = wr; wr_single_i = ws;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   // check n beats of a fixed burst, then idle
   task automatic beats(input string tag, input int c, input int len, input bit il,
                        input int n, input bit e);
      for (int k = 0; k < n; k++) begin
         chk({tag, " valid"}, valid_o, 1);
         chk({tag, " col"}, col_o, exp_col(c, len, il, k));
         chk({tag, " last R9"}, last_o, (k == n - 1) ? 1 : 0);
         chk({tag, " err"}, err_o, e);
         @(negedge clk);
      end
      chk({tag, " idle after last R9"}, valid_o, 0);
   endtask

   task automatic t_reset;
      chk("R12 valid", valid_o, 0);
      chk("R12 last", last_o, 0);
      chk("R12 err", err_o, 0);
   endtask

   task automatic t_seq;
      kick(5, 3, 0, 0, 0);        beats("R3 seq8 s5", 5, 8, 0, 8, 0);
      kick('h1F5, 2, 0, 0, 0);    beats("R2 seq4 upper", 'h1F5, 4, 0, 4, 0);
      kick('h0A3, 1, 0, 0, 0);    beats("R2 seq2", 'h0A3, 2, 0, 2, 0);
   endtask

   task automatic t_il;
      kick(5, 3, 1, 0, 0);        beats("R4 il8 s5", 5, 8, 1, 8, 0);
      kick('h1F5, 2, 1, 0, 0);    beats("R4 il4 upper", 'h1F5, 4, 1, 4, 0);
      kick('h13E, 3, 1, 1, 0);    beats("R4 il8 write", 'h13E, 8, 1, 8, 0);
   endtask

   task automatic t_len1;
      kick('h157, 0, 1, 0, 0);    beats("R6 len1 il", 'h157, 1, 0, 1, 0);
      kick('h157, 0, 0, 0, 0);    beats("R6 len1 seq", 'h157, 1, 0, 1, 0);
   endtask

   task automatic t_page;
      kick(510, 7, 0, 0, 0);
      for (int k = 0; k < 600; k++) begin
         chk("R5 page valid", valid_o, 1);
         chk("R5 page col", col_o, (510 + k) % 512);
         chk("R5 page last", last_o, 0);
         @(negedge clk);
      end
      stop_i = 1'b1;
      @(negedge clk);
      stop_i = 1'b0;
      chk("R11 page stopped", valid_o, 0);
   endtask

   task automatic t_wsingle;
      kick('h044, 3, 0, 1, 1);    beats("R7 write single", 'h044, 1, 0, 1, 0);
      kick('h044, 3, 0, 0, 1);    beats("R7 read keeps len", 'h044, 8, 0, 8, 0);
      kick('h044, 3, 0, 1, 0);    beats("R7 write burst", 'h044, 8, 0, 8, 0);
   endtask

   task automatic t_reserved;
      kick('h0F3, 5, 0, 0, 0);    beats("R8 code101", 'h0F3, 1, 0, 1, 1);
      kick('h0F3, 4, 1, 0, 0);    beats("R8 code100", 'h0F3, 1, 0, 1, 1);
      kick('h1B2, 7, 1, 0, 0);    beats("R8 page il", 'h1B2, 1, 0, 1, 1);
   endtask

   task automatic t_restart;
      kick('h010, 3, 0, 0, 0);
      for (int k = 0; k < 3; k++) begin
         chk("R1 beat", col_o, 'h010 + k);
         if (k < 2) @(negedge clk);
      end
      start_i = 1'b1; col_i = 'h023; len_code_i = 3'b010; interleave_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      beats("R10 restart", 'h023, 4, 1, 4, 0);
      // start together with stop
      kick('h030, 2, 0, 0, 0);
      @(negedge clk);
      start_i = 1'b1; stop_i = 1'b1; col_i = 'h0C1; len_code_i = 3'b001; interleave_i = 1'b0;
      @(negedge clk);
      start_i = 1'b0; stop_i = 1'b0;
      beats("R10 start beats stop", 'h0C1, 2, 0, 2, 0);
   endtask

   task automatic t_stop;
      kick('h100, 3, 0, 0, 0);
      chk("R1 first col", col_o, 'h100);
      @(negedge clk);
      chk("R1 second col", col_o, 'h101);
      stop_i = 1'b1;
      @(negedge clk);
      stop_i = 1'b0;
      chk("R11 stopped", valid_o, 0);
      @(negedge clk);
      chk("R11 stays idle", valid_o, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_seq();
      t_il();
      t_len1();
      t_page();
      t_wsingle();
      t_reserved();
      t_restart();
      t_stop();
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule